// File: doc/BRIEF.md
# Sync-Burst Frame Timing Capture

This block keeps the free-running frame counter that paces a time-slotted frame schedule and ties it to received synchronisation bursts. In each sample slot it receives a signed correlation value and an unsigned received-energy value. The correlation is compared with the energy through a threshold without a divider. When the comparison passes, the block issues a one-cycle frame-clock event to neighbouring logic. It also stores the frame counter value of that slot.

From the stored value the block computes a signed timing error against a programmed expected sync position. The error is held back while a capture is pending. It is handed to a software timing loop only when a later CRC-good indication confirms the burst. A CRC-bad indication throws the capture away, and so does a time-out of one frame. The software loop steers the counter through a one-shot phase offset, applied at the next frame boundary, and through a frame-length input.

Top module: `frame_sync_capture`

## Requirements
- R1: On a slot with `sample_en` high, a detection occurs when `|xcorr|^2 * 2^THR_FRAC >= thr_val * energy^2`. `xcorr` is signed two's complement, `thr_val` is unsigned with THR_FRAC (default 4) fraction bits, and the full-width products are compared without truncation.
- R2: `frame_evt` is high for exactly the cycle after a detecting slot. It is low after any slot that does not detect.
- R3: A detection stores the `frame_cnt` value of the detecting slot in `cap_cnt` and sets `cap_pending`.
- R4: The timing error is d = expected position − captured value, wrapped by frame length L. If 2d > L, L is subtracted; if 2d < −L, L is added. The result is signed and lies in −L/2..+L/2.
- R5: The error appears on `err_value`, with a one-cycle `err_valid` pulse, only in the cycle after `crc_ok` arrives while a capture is pending. The release clears `cap_pending`. If `crc_ok` and `crc_fail` arrive together, `crc_ok` wins.
- R6: A pending capture is discarded without release by `crc_fail`, or after L further sample slots with no confirmation. `err_value` then keeps its previous value.
- R7: After a detection, the next `holdoff_len` sample slots cannot detect.
- R8: `frame_cnt` advances by one on each slot with `sample_en` high and holds otherwise. From L−1 (or above) it wraps to 0 and pulses `frame_start` for one cycle.
- R9: An `adj_valid` strobe stores the signed `adj_offset`. At the next wrap only, the counter loads the offset modulo L instead of 0, and `frame_start` still pulses. The offset must satisfy |offset| < L.
- R10: A detection while a capture is pending, and not being consumed in that cycle, overwrites the capture and sets `cap_overrun`. `cap_overrun` clears when the capture is released or discarded.
- R11: During reset (`rst_n` low, synchronous) the counter, the pending capture, the overrun flag, the hold-off and all pulses are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Marks a sample slot; advances counter and hold-off |
| xcorr | input | MAG_W | Signed correlation value for the slot |
| energy | input | ENG_W | Received energy for the slot |
| thr_val | input | THR_W | Threshold, THR_FRAC fraction bits |
| holdoff_len | input | HOLD_W | Slots masked after a detection |
| period_len | input | CNT_W | Frame length L in slots |
| expect_pos | input | CNT_W | Expected sync position in the frame |
| adj_valid | input | 1 | Strobe to store a phase offset |
| adj_offset | input | CNT_W | Signed phase offset |
| crc_ok | input | 1 | Burst confirmed valid |
| crc_fail | input | 1 | Burst rejected |
| frame_cnt | output | CNT_W | Frame counter |
| frame_start | output | 1 | One-cycle pulse per frame wrap |
| frame_evt | output | 1 | One-cycle frame-clock event |
| cap_cnt | output | CNT_W | Counter value captured at detection |
| cap_pending | output | 1 | A capture awaits CRC outcome |
| cap_overrun | output | 1 | Pending capture was overwritten |
| err_valid | output | 1 | One-cycle release pulse for the error |
| err_value | output | CNT_W+1 | Signed wrapped timing error |

## Verification
The threshold is driven with correlation/energy pairs at exact equality, one step below equality, and with negative or most-negative correlations. This separates a correct squared compare from one that uses the signed value or drops the fraction scaling. Captures at chosen counter positions against chosen expected positions land the difference on each side of the half-frame limits and exactly on them. This shows whether the wrap adds or subtracts L, and where. Confirmation, rejection, time-out and back-to-back detections are sequenced so that each path that frees the pending capture, and the overwrite path, give a different pattern on the release, pending and overrun outputs.

// File: rtl/fsc_pkg.sv
// fsc_pkg: default widths and a width helper shared by the sync capture block.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time constant functions.
package fsc_pkg;
    localparam int unsigned FSC_CNT_W    = 12;
    localparam int unsigned FSC_MAG_W    = 8;
    localparam int unsigned FSC_ENG_W    = 8;
    localparam int unsigned FSC_THR_W    = 8;
    localparam int unsigned FSC_THR_FRAC = 4;
    localparam int unsigned FSC_HOLD_W   = 8;

    // Larger of two widths, used to size comparators.
    function automatic int unsigned fsc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/fsc_detect.sv
// fsc_detect: energy-normalised threshold test with post-detection hold-off.
// Assumes: xcorr is signed two's complement; thr_val carries THR_FRAC fraction
// bits; det_hit is combinational for the current slot, frame_evt is registered.
module fsc_detect
    import fsc_pkg::*;
#(
    parameter int unsigned MAG_W    = FSC_MAG_W,
    parameter int unsigned ENG_W    = FSC_ENG_W,
    parameter int unsigned THR_W    = FSC_THR_W,
    parameter int unsigned THR_FRAC = FSC_THR_FRAC,
    parameter int unsigned HOLD_W   = FSC_HOLD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_en,
    input  logic signed [MAG_W-1:0]  xcorr,
    input  logic        [ENG_W-1:0]  energy,
    input  logic        [THR_W-1:0]  thr_val,
    input  logic        [HOLD_W-1:0] holdoff_len,
    output logic                     det_hit,
    output logic                     frame_evt
);
    localparam int unsigned SQ_W = 2 * MAG_W;
    localparam int unsigned ES_W = 2 * ENG_W;
    localparam int unsigned LW   = SQ_W + THR_FRAC;
    localparam int unsigned RW   = THR_W + ES_W;
    localparam int unsigned CW   = fsc_max(LW, RW);

    logic [MAG_W-1:0]  mag;
    logic [SQ_W-1:0]   mag_sq;
    logic [ES_W-1:0]   eng_sq;
    logic [LW-1:0]     lhs;
    logic [RW-1:0]     rhs;
    logic              meets;
    logic [HOLD_W-1:0] hold_cnt;

    // Magnitude and squares of the slot inputs, full width.
    always_comb begin
        mag    = xcorr[MAG_W-1] ? $unsigned(-xcorr) : $unsigned(xcorr);
        mag_sq = {{MAG_W{1'b0}}, mag} * {{MAG_W{1'b0}}, mag};
        eng_sq = {{ENG_W{1'b0}}, energy} * {{ENG_W{1'b0}}, energy};
        lhs    = LW'(mag_sq) << THR_FRAC;
        rhs    = {{ES_W{1'b0}}, thr_val} * {{THR_W{1'b0}}, eng_sq};
        meets  = CW'(lhs) >= CW'(rhs);
        det_hit = sample_en && (hold_cnt == '0) && meets;
    end

    // Event register and hold-off down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            frame_evt <= 1'b0;
        end else begin
            frame_evt <= det_hit;
            if (det_hit) begin
                hold_cnt <= holdoff_len;
            end else if (sample_en && hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

    // R7: a slot inside the hold-off window never raises an event.
    p_holdoff_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && hold_cnt != '0) |=> !frame_evt);

    // R2: an event only follows a real sample slot.
    p_evt_after_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |-> $past(sample_en));
endmodule

// File: rtl/fsc_counter.sv
// fsc_counter: frame counter that wraps at the programmed length, with a
// one-shot phase offset applied at the next wrap.
// Assumes: period_len >= 2 and |adj_offset| < period_len.
module fsc_counter
    import fsc_pkg::*;
#(
    parameter int unsigned CNT_W = FSC_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [CNT_W-1:0] period_len,
    input  logic             adj_valid,
    input  logic [CNT_W-1:0] adj_offset,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_start
);
    logic             adj_pend;
    logic [CNT_W-1:0] adj_val;
    logic [CNT_W-1:0] adj_load;
    logic             at_end;

    // Offset reduced modulo the frame length, and wrap detection.
    always_comb begin
        adj_load = adj_val[CNT_W-1] ? (period_len + adj_val) : adj_val;
        at_end   = sample_en && (cnt >= period_len - 1'b1);
    end

    // Counter, wrap pulse and pending-offset bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            frame_start <= 1'b0;
            adj_pend    <= 1'b0;
            adj_val     <= '0;
        end else begin
            frame_start <= at_end;
            if (at_end) begin
                cnt      <= adj_pend ? adj_load : '0;
                adj_pend <= adj_valid;
            end else begin
                if (sample_en) cnt <= cnt + 1'b1;
                if (adj_valid) adj_pend <= 1'b1;
            end
            if (adj_valid) adj_val <= adj_offset;
        end
    end

    // R8: without an offset waiting, the frame end returns to zero with a pulse.
    p_wrap_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && cnt >= period_len - 1'b1 && !adj_pend) |=> (cnt == '0 && frame_start));

    // R8: the counter holds between sample slots.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(cnt));

    // R9: an applied offset is consumed unless a new strobe came with the wrap.
    p_adj_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && adj_pend && !adj_valid) |=> !adj_pend);
endmodule

// File: rtl/fsc_capture.sv
// fsc_capture: single-entry capture of the counter at detection, wrapped error
// computation and CRC-gated release with reject and time-out paths.
// Assumes: period_len >= 2; crc_ok has priority over crc_fail.
module fsc_capture
    import fsc_pkg::*;
#(
    parameter int unsigned CNT_W = FSC_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic                    det_hit,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic [CNT_W-1:0]        expect_pos,
    input  logic [CNT_W-1:0]        period_len,
    input  logic                    crc_ok,
    input  logic                    crc_fail,
    output logic [CNT_W-1:0]        cap_q,
    output logic                    pending,
    output logic                    overrun,
    output logic                    err_valid,
    output logic signed [CNT_W:0]   err_out
);
    localparam int unsigned DW = CNT_W + 2;
    localparam int unsigned EW = CNT_W + 1;

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] twice;
    logic signed [DW-1:0] lenx;
    logic signed [DW-1:0] wrapped;
    logic signed [EW-1:0] err_now;
    logic signed [EW-1:0] err_pend;
    logic [CNT_W-1:0]     tmo;
    logic                 timeout;
    logic                 consume;

    // Signed difference folded into the half-frame window.
    always_comb begin
        diff  = $signed({2'b00, expect_pos}) - $signed({2'b00, cnt_in});
        twice = diff <<< 1;
        lenx  = $signed({2'b00, period_len});
        if (twice > lenx)       wrapped = diff - lenx;
        else if (twice < -lenx) wrapped = diff + lenx;
        else                    wrapped = diff;
        err_now = wrapped[EW-1:0];
        timeout = pending && sample_en && (tmo == period_len - 1'b1);
        consume = pending && (crc_ok || crc_fail || timeout);
    end

    // Pending capture, overrun flag, time-out count and release register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            pending   <= 1'b0;
            overrun   <= 1'b0;
            err_valid <= 1'b0;
            err_out   <= '0;
            err_pend  <= '0;
            tmo       <= '0;
        end else begin
            err_valid <= 1'b0;
            if (pending && crc_ok) begin
                err_valid <= 1'b1;
                err_out   <= err_pend;
            end
            if (det_hit) begin
                cap_q    <= cnt_in;
                err_pend <= err_now;
                pending  <= 1'b1;
                tmo      <= '0;
                overrun  <= pending && !consume;
            end else if (consume) begin
                pending <= 1'b0;
                overrun <= 1'b0;
            end else if (pending && sample_en) begin
                tmo <= tmo + 1'b1;
            end
        end
    end

    // R3: a detection stores the counter seen in that slot and arms the entry.
    p_cap_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        det_hit |=> (cap_q == $past(cnt_in) && pending));

    // R4: the held error never leaves the half-frame window.
    p_err_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> ($signed({err_pend, 1'b0}) <= $signed({2'b00, period_len}) &&
                     $signed({err_pend, 1'b0}) >= -$signed({2'b00, period_len})));

    // R5: a release needs a pending capture and a CRC-good indication.
    p_release_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(pending && crc_ok));

    // R6: a rejection without a new detection empties the entry.
    p_reject_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_fail && !det_hit) |=> !pending);

    // R10: overwriting a live capture raises the overrun flag.
    p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (det_hit && pending && !crc_ok && !crc_fail && !timeout) |=> overrun);
endmodule

// File: rtl/frame_sync_capture.sv
// frame_sync_capture: top level tying the threshold detector, the frame
// counter and the CRC-gated capture together.
// Assumes: one sample slot per cycle with sample_en high; period_len >= 2.
module frame_sync_capture
    import fsc_pkg::*;
#(
    parameter int unsigned CNT_W    = FSC_CNT_W,
    parameter int unsigned MAG_W    = FSC_MAG_W,
    parameter int unsigned ENG_W    = FSC_ENG_W,
    parameter int unsigned THR_W    = FSC_THR_W,
    parameter int unsigned THR_FRAC = FSC_THR_FRAC,
    parameter int unsigned HOLD_W   = FSC_HOLD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic signed [MAG_W-1:0] xcorr,
    input  logic [ENG_W-1:0]        energy,
    input  logic [THR_W-1:0]        thr_val,
    input  logic [HOLD_W-1:0]       holdoff_len,
    input  logic [CNT_W-1:0]        period_len,
    input  logic [CNT_W-1:0]        expect_pos,
    input  logic                    adj_valid,
    input  logic [CNT_W-1:0]        adj_offset,
    input  logic                    crc_ok,
    input  logic                    crc_fail,
    output logic [CNT_W-1:0]        frame_cnt,
    output logic                    frame_start,
    output logic                    frame_evt,
    output logic [CNT_W-1:0]        cap_cnt,
    output logic                    cap_pending,
    output logic                    cap_overrun,
    output logic                    err_valid,
    output logic signed [CNT_W:0]   err_value
);
    logic det_hit;

    fsc_detect #(
        .MAG_W(MAG_W), .ENG_W(ENG_W), .THR_W(THR_W),
        .THR_FRAC(THR_FRAC), .HOLD_W(HOLD_W)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .xcorr(xcorr), .energy(energy), .thr_val(thr_val),
        .holdoff_len(holdoff_len), .det_hit(det_hit), .frame_evt(frame_evt)
    );

    fsc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .period_len(period_len), .adj_valid(adj_valid), .adj_offset(adj_offset),
        .cnt(frame_cnt), .frame_start(frame_start)
    );

    fsc_capture #(.CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .det_hit(det_hit),
        .cnt_in(frame_cnt), .expect_pos(expect_pos), .period_len(period_len),
        .crc_ok(crc_ok), .crc_fail(crc_fail), .cap_q(cap_cnt),
        .pending(cap_pending), .overrun(cap_overrun),
        .err_valid(err_valid), .err_out(err_value)
    );
endmodule

// File: tb/frame_sync_capture_bench.sv
`timescale 1ns/1ps
module frame_sync_capture_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b1;
    logic signed [7:0] xcorr = '0;
    logic [7:0]        energy = 8'd10;
    logic [7:0]        thr_val = 8'd16;
    logic [7:0]        holdoff_len = '0;
    logic [11:0]       period_len = 12'd16;
    logic [11:0]       expect_pos = 12'd4;
    logic              adj_valid = 1'b0;
    logic [11:0]       adj_offset = '0;
    logic              crc_ok = 1'b0;
    logic              crc_fail = 1'b0;
    logic [11:0]       frame_cnt;
    logic              frame_start;
    logic              frame_evt;
    logic [11:0]       cap_cnt;
    logic              cap_pending;
    logic              cap_overrun;
    logic              err_valid;
    logic signed [12:0] err_value;

    int checks = 0;
    int fails  = 0;

    frame_sync_capture u_frame_sync_capture (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .xcorr(xcorr),
        .energy(energy), .thr_val(thr_val), .holdoff_len(holdoff_len),
        .period_len(period_len), .expect_pos(expect_pos),
        .adj_valid(adj_valid), .adj_offset(adj_offset),
        .crc_ok(crc_ok), .crc_fail(crc_fail), .frame_cnt(frame_cnt),
        .frame_start(frame_start), .frame_evt(frame_evt), .cap_cnt(cap_cnt),
        .cap_pending(cap_pending), .cap_overrun(cap_overrun),
        .err_valid(err_valid), .err_value(err_value)
    );

    always #10 clk = ~clk;

    // Threshold vectors: {xcorr, energy, thr_val, expected detection}.
    localparam logic [31:0] VEC [10] = '{
        {8'd10,  8'd10,  8'd16, 8'd1},
        {8'd9,   8'd10,  8'd16, 8'd0},
        {8'hF6,  8'd10,  8'd16, 8'd1},
        {8'hF7,  8'd10,  8'd16, 8'd0},
        {8'd5,   8'd10,  8'd4,  8'd1},
        {8'd5,   8'd10,  8'd5,  8'd0},
        {8'd20,  8'd40,  8'd4,  8'd1},
        {8'h80,  8'd127, 8'd16, 8'd1},
        {8'd127, 8'd128, 8'd16, 8'd0},
        {8'd0,   8'd1,   8'd1,  8'd0}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cnt(input int v);
        while (frame_cnt != 12'(v)) tick;
    endtask

    task automatic fire;
        xcorr = 8'sd50; energy = 8'd10; thr_val = 8'd16;
        tick;
        xcorr = '0;
    endtask

    task automatic cap_release(input int e, input int at, input int exp_err, input string tag);
        expect_pos = 12'(e);
        wait_cnt(at);
        fire;
        chk({tag, " R3 cap_cnt"}, cap_cnt, at);
        chk({tag, " R5 held before crc"}, err_valid, 0);
        crc_ok = 1'b1;
        tick;
        crc_ok = 1'b0;
        chk({tag, " R5 err_valid"}, err_valid, 1);
        chk({tag, " R4 err_value"}, err_value, exp_err);
        chk({tag, " R5 pending cleared"}, cap_pending, 0);
        tick;
        chk({tag, " R5 pulse one cycle"}, err_valid, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) tick;
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 frame_cnt", frame_cnt, 0);
        chk("R11 frame_evt", frame_evt, 0);
        chk("R11 cap_pending", cap_pending, 0);
        chk("R11 cap_overrun", cap_overrun, 0);
        chk("R11 err_valid", err_valid, 0);
        chk("R11 frame_start", frame_start, 0);

        // R1 / R2 threshold table
        for (int i = 0; i < 10; i++) begin
            xcorr = VEC[i][31:24]; energy = VEC[i][23:16]; thr_val = VEC[i][15:8];
            tick;
            chk($sformatf("R1 vector %0d", i), frame_evt, VEC[i][0]);
            xcorr = '0; crc_fail = 1'b1;
            tick;
            crc_fail = 1'b0;
            chk($sformatf("R2 vector %0d pulse width", i), frame_evt, 0);
        end
        energy = 8'd10; thr_val = 8'd16;

        // R8 wrap, stall and shorter frame
        wait_cnt(15);
        tick;
        chk("R8 wrap to zero", frame_cnt, 0);
        chk("R8 frame_start", frame_start, 1);
        tick;
        chk("R8 frame_start one cycle", frame_start, 0);
        chk("R8 advance", frame_cnt, 1);
        sample_en = 1'b0;
        repeat (3) tick;
        chk("R8 stall holds", frame_cnt, 1);
        sample_en = 1'b1;
        period_len = 12'd10;
        wait_cnt(9);
        tick;
        chk("R8 wrap at L=10", frame_cnt, 0);
        chk("R8 frame_start at L=10", frame_start, 1);
        period_len = 12'd16;

        // R3 R4 R5 capture, wrap window and release
        cap_release(4, 7, -3, "plain");
        cap_release(1, 14, 3, "wrap up");
        cap_release(1, 9, -8, "edge -L/2");
        cap_release(9, 0, -7, "wrap down");
        cap_release(12, 4, 8, "edge +L/2");

        // R6 CRC reject
        wait_cnt(5);
        fire;
        chk("R6 pending before reject", cap_pending, 1);
        crc_fail = 1'b1;
        tick;
        crc_fail = 1'b0;
        chk("R6 reject clears", cap_pending, 0);
        crc_ok = 1'b1;
        tick;
        crc_ok = 1'b0;
        chk("R6 no release after reject", err_valid, 0);
        chk("R6 err_value kept", err_value, 8);

        // R6 time-out after L slots
        fire;
        repeat (15) tick;
        chk("R6 still pending at L-1", cap_pending, 1);
        tick;
        chk("R6 time-out clears", cap_pending, 0);
        crc_ok = 1'b1;
        tick;
        crc_ok = 1'b0;
        chk("R6 no release after time-out", err_valid, 0);

        // R10 overrun
        expect_pos = 12'd4;
        wait_cnt(2);
        fire;
        chk("R10 no overrun first", cap_overrun, 0);
        tick;
        fire;
        chk("R10 overrun set", cap_overrun, 1);
        chk("R10 capture overwritten", cap_cnt, 4);
        crc_ok = 1'b1;
        tick;
        crc_ok = 1'b0;
        chk("R10 second capture released", err_value, 0);
        chk("R10 overrun cleared", cap_overrun, 0);

        // R7 hold-off
        holdoff_len = 8'd3;
        xcorr = 8'sd50;
        tick;
        chk("R7 first detection", frame_evt, 1);
        for (int k = 0; k < 3; k++) begin
            tick;
            chk($sformatf("R7 masked slot %0d", k), frame_evt, 0);
        end
        tick;
        chk("R7 detection after window", frame_evt, 1);
        xcorr = '0; crc_fail = 1'b1;
        tick;
        crc_fail = 1'b0;
        holdoff_len = '0;

        // R9 one-shot phase offsets
        wait_cnt(3);
        adj_valid = 1'b1; adj_offset = 12'd5;
        tick;
        adj_valid = 1'b0;
        wait_cnt(15);
        tick;
        chk("R9 positive offset loaded", frame_cnt, 5);
        chk("R9 frame_start with offset", frame_start, 1);
        wait_cnt(15);
        tick;
        chk("R9 offset applied once", frame_cnt, 0);
        wait_cnt(3);
        adj_valid = 1'b1; adj_offset = 12'hFFD;
        tick;
        adj_valid = 1'b0;
        wait_cnt(15);
        tick;
        chk("R9 negative offset modulo L", frame_cnt, 13);
        wait_cnt(15);
        tick;
        chk("R9 negative offset once", frame_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule